// File: doc/BRIEF.md
# Direct Single-Word Bus Access Unit

This unit runs exactly one external bus cycle on request from software, without any FIFO. Software programs a small register port. The control/status register holds the enable, direction, start and done flags. A separate address register holds the bus address, and a data register holds the word to send or the word that came back. Once a start is accepted, the unit asks for the shared bus with a one-bit request and waits for the grant. It then walks through four timed phases: setup, strobe, hold and pace.

Timing lengths and the bus width (8 or 16 bits) come from configuration inputs that are shared with the programmed transfer engine. When the pace phase ends, the unit raises done and gives up the bus. For a read, the data register then holds the captured word. Writing the control register with enable clear aborts any cycle in progress and returns the unit to idle.

Top module: `dsa_unit`

## Requirements
- R1: After reset the control/status, address and data registers read 0. `gnt_req`, `bus_oe`, `bus_rd_stb` and `bus_wr_stb` are low, and `bus_addr` is 0.
- R2: The register map uses `reg_sel` 0 for control/status, 1 for address and 2 for data.
  - In control/status, bit 0 is enable, bit 1 is write (1 = write cycle), bit 2 is start (always reads 0) and bit 3 is done (read-only).
  - Address reads back zero-extended to `AW` bits. Data reads back as the low 16 bits.
  - While the unit is idle, writes to all three registers take effect.
- R3: A control write that sets start with enable clear starts nothing: `gnt_req` stays low.
- R4: The clock after an accepted start, `gnt_req` rises. Until `gnt_ack` is seen, the bus is not driven and no strobe appears.
- R5: After the grant, the phases run in order. Setup, strobe, hold and pace last `cfg_setup+1`, `cfg_strobe+1`, `cfg_hold+1` and `cfg_pace+1` clocks. With the grant already present, done reads 1 exactly `cfg_setup+cfg_strobe+cfg_hold+cfg_pace+5` clocks after the accepting edge.
- R6: A read captures `bus_din` on the last strobe clock into the data register. In 8-bit mode (`cfg_wide`=0) only bits 7:0 are kept and the upper byte reads 0.
- R7: A write drives `bus_oe` with `bus_dout` equal to the data register during setup, strobe and hold. In 8-bit mode the upper byte of `bus_dout` is 0.
- R8: Done clears when a start is accepted and stays set after completion until the next accepted start.
- R9: A start written while a cycle is in progress is ignored: exactly one strobe occurs and the done timing is unchanged.
- R10: A control write with enable clear aborts any cycle and releases `gnt_req` on the next clock. Done stays 0 and no strobe follows.
- R11: `bus_addr` equals the address register while the unit owns the bus (setup to pace) and is 0 otherwise. `bus_rd_stb` marks the strobe phase of reads and `bus_wr_stb` marks the strobe phase of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 ctrl, 1 address, 2 data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| cfg_wide | input | 1 | 1 = 16-bit bus word, 0 = 8-bit |
| cfg_setup | input | TW | Setup phase length minus one |
| cfg_strobe | input | TW | Strobe phase length minus one |
| cfg_hold | input | TW | Hold phase length minus one |
| cfg_pace | input | TW | Pace phase length minus one |
| gnt_req | output | 1 | Bus request to the arbiter |
| gnt_ack | input | 1 | Bus grant |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | Write data to the bus |
| bus_oe | output | 1 | Data output enable |
| bus_din | input | DW | Read data from the bus |
| bus_rd_stb | output | 1 | Read strobe |
| bus_wr_stb | output | 1 | Write strobe |

## Verification
Done is due a fixed number of clocks after the accepting edge: the sum of the four fields plus five. When the grant is delayed, done moves out by the delay. The bench counts falling edges from the one that follows the start write and compares that count with the sum. A grant held low for three clocks shifts the expected count by three, and a repeated start during the strobe phase must leave the count unchanged. Strobe width, address and write data are checked by a monitor on falling edges against items the driver queued. Read data and done are sampled from the register port only after done appears.

// File: rtl/dsa_unit.sv
module dsa_unit #(
  parameter int AW = 6,
  parameter int TW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          cfg_wide,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_strobe,
  input  logic [TW-1:0] cfg_hold,
  input  logic [TW-1:0] cfg_pace,
  output logic          gnt_req,
  input  logic          gnt_ack,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din,
  output logic          bus_rd_stb,
  output logic          bus_wr_stb
);
  localparam int BW = DW / 2;
  localparam logic [2:0] S_IDLE = 3'd0, S_REQ = 3'd1, S_SETUP = 3'd2,
                         S_STRB = 3'd3, S_HOLD = 3'd4, S_PACE = 3'd5;

  logic [2:0]    st;
  logic [TW-1:0] cnt, plen;
  logic          en_q, wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  wire ctrl_we  = reg_we && reg_sel == 2'd0;
  wire idle     = st == S_IDLE;
  wire start_ok = ctrl_we && reg_wdata[0] && reg_wdata[2] && idle;
  wire own      = st >= S_SETUP;
  wire pend     = cnt == plen;

  always_comb begin
    case (st)
      S_SETUP: plen = cfg_setup;
      S_STRB:  plen = cfg_strobe;
      S_HOLD:  plen = cfg_hold;
      default: plen = cfg_pace;
    endcase
  end

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] w, input logic wide);
    return wide ? w : {{(DW-BW){1'b0}}, w[BW-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; en_q <= 1'b0; wr_q <= 1'b0;
      done_q <= 1'b0; addr_q <= '0; data_q <= '0;
    end else begin
      case (st)
        S_REQ: if (gnt_ack) begin st <= S_SETUP; cnt <= '0; end
        S_SETUP, S_STRB, S_HOLD, S_PACE:
          if (pend) begin
            cnt <= '0;
            if (st == S_STRB && !wr_q) data_q <= fit(bus_din, cfg_wide);
            if (st == S_PACE) begin st <= S_IDLE; done_q <= 1'b1; end
            else st <= st + 3'd1;
          end else cnt <= cnt + 1'b1;
        default: ;
      endcase
      if (idle && reg_we && reg_sel == 2'd1) addr_q <= reg_wdata[AW-1:0];
      if (idle && reg_we && reg_sel == 2'd2) data_q <= reg_wdata[DW-1:0];
      if (ctrl_we && (idle || !reg_wdata[0])) begin
        en_q <= reg_wdata[0];
        wr_q <= reg_wdata[1];
      end
      if (ctrl_we && !reg_wdata[0]) begin
        st <= S_IDLE; cnt <= '0;
      end else if (start_ok) begin
        st <= S_REQ; cnt <= '0; done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {28'd0, done_q, 1'b0, wr_q, en_q};
      2'd1:    reg_rdata = {{(32-AW){1'b0}}, addr_q};
      2'd2:    reg_rdata = {{(32-DW){1'b0}}, data_q};
      default: reg_rdata = '0;
    endcase
  end

  assign gnt_req    = !idle;
  assign bus_addr   = own ? addr_q : '0;
  assign bus_oe     = wr_q && own && st != S_PACE;
  assign bus_dout   = bus_oe ? fit(data_q, cfg_wide) : '0;
  assign bus_rd_stb = !wr_q && st == S_STRB;
  assign bus_wr_stb = wr_q && st == S_STRB;
endmodule

// File: rtl/dsa_unit_chk.sv
module dsa_unit_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [1:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic [2:0]    st,
  input logic          done_q,
  input logic          gnt_req,
  input logic          gnt_ack,
  input logic          bus_oe,
  input logic          bus_rd_stb,
  input logic          bus_wr_stb,
  input logic [AW-1:0] bus_addr
);
  wire ctrl_we  = reg_we && reg_sel == 2'd0;
  wire start_wr = ctrl_we && reg_wdata[0] && reg_wdata[2];

  a_r4_no_drive_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe || bus_rd_stb || bus_wr_stb) |-> (gnt_req && gnt_ack));
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_stb && bus_wr_stb));
  a_r7_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_stb |-> !bus_oe);
  a_r8_done_cleared_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && start_wr) |=> (!done_q && gnt_req));
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st >= 3'd2 && start_wr) |=> st != 3'd1);
  a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !reg_wdata[0]) |=> !gnt_req);
  a_r11_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_req |-> bus_addr == '0);
  a_r5_done_after_pace: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(st) == 3'd5 && !gnt_req));
endmodule

bind dsa_unit dsa_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .st(st), .done_q(done_q), .gnt_req(gnt_req),
  .gnt_ack(gnt_ack), .bus_oe(bus_oe), .bus_rd_stb(bus_rd_stb),
  .bus_wr_stb(bus_wr_stb), .bus_addr(bus_addr)
);

// File: tb/dsa_unit_tb.sv
module dsa_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, TW = 6, DW = 16;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_sel = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic cfg_wide = 1;
  logic [TW-1:0] cfg_setup = 0, cfg_strobe = 0, cfg_hold = 0, cfg_pace = 0;
  logic gnt_req, gnt_ack = 1;
  logic [AW-1:0] bus_addr; logic [DW-1:0] bus_dout, bus_din = 0;
  logic bus_oe, bus_rd_stb, bus_wr_stb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsa_unit #(.AW(AW), .TW(TW), .DW(DW)) dut_i (.*);

  typedef struct { bit wr; logic [AW-1:0] addr; logic [DW-1:0] data; int slen; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  item_t cur; bit in_stb = 0; int slen_seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (bus_rd_stb || bus_wr_stb) begin
      if (!in_stb) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9/R10 unexpected strobe actual 1 expected 0");
        end else cur = exp_q.pop_front();
        in_stb = 1; slen_seen = 0;
        chk("R11 strobe direction", {31'd0, bus_wr_stb}, {31'd0, cur.wr});
        chk("R11 bus address", bus_addr, cur.addr);
      end
      if (cur.wr) begin
        chk("R7 write oe", bus_oe, 1);
        chk("R7 write data", bus_dout, cur.data);
      end
      slen_seen++;
    end else if (in_stb) begin
      in_stb = 0;
      chk("R5 strobe length", slen_seen, cur.slen);
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rreg(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic timing(input int s, input int t, input int h, input int p, input bit w);
    cfg_setup = TW'(s); cfg_strobe = TW'(t); cfg_hold = TW'(h); cfg_pace = TW'(p); cfg_wide = w;
  endtask

  task automatic wait_done(inout int i);
    logic [31:0] v;
    forever begin
      rreg(0, v);
      if (v[3] || i > 500) break;
      @(negedge clk); i++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; int i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rreg(0, v); chk("R1 ctrl reset", v, 0);
    rreg(1, v); chk("R1 addr reset", v, 0);
    rreg(2, v); chk("R1 data reset", v, 0);
    chk("R1 bus idle", {gnt_req, bus_oe, bus_rd_stb, bus_wr_stb}, 0);
    chk("R1 bus addr", bus_addr, 0);
    // R2 register map
    wreg(1, 32'hFFFF_FFFF); rreg(1, v); chk("R2 addr readback", v, 32'h3F);
    wreg(2, 32'h0001_A5A5); rreg(2, v); chk("R2 data readback", v, 32'hA5A5);
    wreg(0, 32'h3); rreg(0, v); chk("R2 ctrl readback", v, 32'h3);
    wreg(0, 0);
    // R3 start without enable
    wreg(0, 32'h4);
    repeat (3) @(negedge clk);
    chk("R3 no request", gnt_req, 0);
    rreg(0, v); chk("R3 ctrl unchanged", v, 0);
    // R5 R6 16-bit read
    timing(1, 3, 1, 1, 1); bus_din = 16'hBEEF;
    wreg(1, 32'h15); wreg(0, 32'h1);
    exp_q.push_back('{0, 6'h15, 16'h0, 4});
    wreg(0, 32'h5); i = 0;
    chk("R4 request after accept", gnt_req, 1);
    wait_done(i); chk("R5 done latency read16", i, 11);
    rreg(2, v); chk("R6 read16 data", v, 32'hBEEF);
    repeat (3) @(negedge clk);
    rreg(0, v); chk("R8 done sticks", v[3], 1);
    chk("R11 addr after cycle", bus_addr, 0);
    // R7 8-bit write, minimal timing
    timing(0, 0, 0, 0, 0);
    wreg(0, 32'h3); wreg(2, 32'h1234); wreg(1, 32'h2A);
    exp_q.push_back('{1, 6'h2A, 16'h0034, 1});
    wreg(0, 32'h7); i = 0;
    rreg(0, v); chk("R8 done cleared on start", v[3], 0);
    wait_done(i); chk("R5 done latency write8", i, 5);
    // R6 8-bit read zero-extend
    timing(2, 1, 0, 3, 0); bus_din = 16'hABCD;
    wreg(1, 32'h3); wreg(0, 32'h1);
    exp_q.push_back('{0, 6'h3, 16'h0, 2});
    wreg(0, 32'h5); i = 0;
    wait_done(i); chk("R5 done latency read8", i, 11);
    rreg(2, v); chk("R6 read8 zero-extended", v, 32'h00CD);
    // R9 start while busy
    timing(0, 5, 0, 0, 1); bus_din = 16'h5A5A;
    wreg(0, 32'h1);
    exp_q.push_back('{0, 6'h3, 16'h0, 6});
    wreg(0, 32'h5); i = 0;
    @(negedge clk); @(negedge clk); i = 2;
    wreg(0, 32'h5); i = 3;
    wait_done(i); chk("R9 latency unchanged", i, 10);
    rreg(2, v); chk("R9 read data", v, 32'h5A5A);
    // R4 delayed grant
    timing(1, 1, 1, 1, 1); gnt_ack = 0;
    wreg(0, 32'h3); wreg(2, 32'hC3C3); wreg(1, 32'h7);
    exp_q.push_back('{1, 6'h7, 16'hC3C3, 2});
    wreg(0, 32'h7); i = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); i++;
      chk("R4 waiting request", gnt_req, 1);
      chk("R4 no drive before grant", {bus_oe, bus_rd_stb, bus_wr_stb}, 0);
    end
    gnt_ack = 1;
    wait_done(i); chk("R4 latency with grant delay", i, 12);
    // R10 abort
    timing(6, 0, 0, 0, 1);
    wreg(0, 32'h1); wreg(0, 32'h5);
    @(negedge clk); @(negedge clk);
    wreg(0, 32'h0);
    chk("R10 request released", gnt_req, 0);
    rreg(0, v); chk("R10 ctrl after abort", v, 0);
    repeat (12) @(negedge clk);
    chk("R10 still idle", {gnt_req, bus_oe, bus_rd_stb, bus_wr_stb}, 0);
    chk("R5 all expected strobes seen", exp_q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule